// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a parameterised set of interrupt sources (up to 32) into one active-high request line for a processor. Each source is fixed at build time as either edge-sensitive (it latches on a rising edge) or level-sensitive (it latches on every cycle the input is high). Latched sources are held in a status word. Software clears them through an acknowledge word, masks them through an enable word, and reads the number of the most urgent source from a vector word.

Software reaches the block through a simple 32-bit register bus. Writes are strobed and take effect at the next clock edge, and reads are combinational from the current state. A two-bit master control word has two jobs. One bit gates the request line. The other bit hands the status word over to the hardware inputs. Until that bit is set, software may raise status bits itself to test its handlers. Once it is set, it stays set until reset.

Top module: `vic_top`

## Requirements
- R1: Word offsets (byte address bits [4:2]) select: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. Acknowledge, set-enable and clear-enable read as zero.
- R2: A write to offset 2 loads the enable word, so writing zero disables every source.
- R3: A write to offset 4 ORs the written mask into the enable word and leaves the other bits unchanged.
- R4: A write to offset 5 clears each enable bit written as one and leaves the other bits unchanged.
- R5: A write to offset 3 clears each status bit written as one. Writing all ones clears the whole status word.
- R6: A level-sensitive source that is still high when acknowledged stays set in status. Once the input is low, an acknowledge clears it.
- R7: An edge-sensitive source (kind bit 1) sets its status bit only on a 0-to-1 change of its input. If the input is held high, an acknowledge clears the bit and it stays clear.
- R8: Pending reads as status AND enable. The vector reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when nothing is pending.
- R9: The request output is registered: one edge after a change, it equals master bit 0 AND (pending is nonzero).
- R10: Master control bit 0 is the request gate and bit 1 is the hardware-input enable, and both read back. Once bit 1 is set, it cannot be cleared before reset.
- R11: While master bit 1 is clear, hardware inputs are ignored and a write to offset 0 ORs its data into status. While bit 1 is set, such writes are ignored.
- R12: Bits at and above the parameterised source count read as zero in every word, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Interrupt source inputs |
| bus_we | input | 1 | Write strobe, committed at the next rising edge |
| bus_addr | input | 5 | Byte address; bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A register write is visible to a read immediately after the edge that commits it, because reads have no latency. That covers status, enable, pending, vector and the master word alike. A source input change reaches status after exactly one edge, and the request output follows pending one edge later still. The bench therefore drives every input on a falling edge and reads shortly after it. It waits one extra edge only before sampling the request line.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [2:0] {
        RG_STAT  = 3'd0,
        RG_PEND  = 3'd1,
        RG_EN    = 3'd2,
        RG_ACK   = 3'd3,
        RG_SETEN = 3'd4,
        RG_CLREN = 3'd5,
        RG_VEC   = 3'd6,
        RG_MCTL  = 3'd7
    } reg_idx_e;

    localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
    parameter int unsigned N_SRC = 32,
    parameter logic [N_SRC-1:0] KIND = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             hw_on_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_SRC-1:0] swset_i,
    output logic [N_SRC-1:0] status_o
);
    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] sts;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_kind
        if (KIND[g]) begin : g_edge
            assign hit[g] = src_i[g] & ~cap_q.prev[g];
        end else begin : g_level
            assign hit[g] = src_i[g];
        end
    end

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = src_i;
        cap_d.sts  = (cap_q.sts & ~clr_i) | (hit & {N_SRC{hw_on_i}}) | swset_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign status_o = cap_q.sts;

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_on_i && swset_i == '0) |=> ((cap_q.sts & $past(clr_i)) == '0));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int unsigned N_SRC = 32
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic             any_o,
    output logic [31:0]      vec_o
);
    always_comb begin
        vec_o = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) vec_o = 32'(i);
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int unsigned N_SRC = 32,
    parameter logic [N_SRC-1:0] KIND = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             bus_we,
    input  logic [4:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o
);
    import vic_pkg::*;

    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic             me;
        logic             hie;
        logic             irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    reg_idx_e         widx;
    logic [N_SRC-1:0] wmask;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] ack_m;
    logic [N_SRC-1:0] sw_m;
    logic             any;
    logic [31:0]      vec;

    assign widx  = reg_idx_e'(bus_addr[4:2]);
    assign wmask = bus_wdata[N_SRC-1:0];
    assign ack_m = (bus_we && widx == RG_ACK) ? wmask : '0;
    assign sw_m  = (bus_we && widx == RG_STAT && !ctl_q.hie) ? wmask : '0;
    assign pend  = status & ctl_q.en;

    vic_capture #(.N_SRC(N_SRC), .KIND(KIND)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .hw_on_i  (ctl_q.hie),
        .clr_i    (ack_m),
        .swset_i  (sw_m),
        .status_o (status)
    );

    vic_prio #(.N_SRC(N_SRC)) u_prio (
        .pend_i (pend),
        .any_o  (any),
        .vec_o  (vec)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = ctl_q.me & any;
        if (bus_we) begin
            unique case (widx)
                RG_EN:    ctl_d.en = wmask;
                RG_SETEN: ctl_d.en = ctl_q.en | wmask;
                RG_CLREN: ctl_d.en = ctl_q.en & ~wmask;
                RG_MCTL: begin
                    ctl_d.me  = bus_wdata[0];
                    ctl_d.hie = ctl_q.hie | bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            RG_STAT: bus_rdata[N_SRC-1:0] = status;
            RG_PEND: bus_rdata[N_SRC-1:0] = pend;
            RG_EN:   bus_rdata[N_SRC-1:0] = ctl_q.en;
            RG_VEC:  bus_rdata = vec;
            RG_MCTL: bus_rdata[1:0] = {ctl_q.hie, ctl_q.me};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = ctl_q.irq;

    // R3
    seten_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && widx == RG_SETEN) |=> ((ctl_q.en & $past(wmask)) == $past(wmask)));
    // R4
    clren_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && widx == RG_CLREN) |=> ((ctl_q.en & $past(wmask)) == '0));
    // R10
    hie_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.hie |=> ctl_q.hie);
    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.me && pend != '0) |=> irq_o);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.me |=> !irq_o);
    // R8
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (vec == 32'hFFFF_FFFF));
    // R8
    vec_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (vec < N_SRC && pend[vec[4:0]]));
endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;
    localparam int unsigned N = 8;
    localparam logic [N-1:0] KD = 8'hF0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         we = 1'b0;
    logic [4:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vic_top #(.N_SRC(N), .KIND(KD)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int off, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = 5'(off * 4); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int off, output logic [31:0] d);
        addr = 5'(off * 4);
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] lowest(logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1)
        rd(0, v); chk("R1 status reset", v, 0);
        rd(1, v); chk("R1 pending reset", v, 0);
        rd(2, v); chk("R1 enable reset", v, 0);
        rd(6, v); chk("R8 vector reset", v, 32'hFFFF_FFFF);
        rd(7, v); chk("R10 master reset", v, 0);
        chk("R9 irq reset", 32'(irq), 0);
        // R12 upper bits
        wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R12 enable width", v, 32'h0000_00FF);
        // R2
        wr(2, 0); rd(2, v); chk("R2 zero disables", v, 0);
        // R3 / R4
        wr(4, 32'h05); wr(4, 32'h30); rd(2, v); chk("R3 set-enable OR", v, 32'h35);
        wr(5, 32'h11); rd(2, v); chk("R4 clear-enable", v, 32'h24);
        // R1 alias reads
        rd(3, v); chk("R1 ack reads zero", v, 0);
        rd(4, v); chk("R1 seten reads zero", v, 0);
        rd(5, v); chk("R1 clren reads zero", v, 0);
        // R11 hw inputs ignored before HIE
        src = 8'h02; @(negedge clk); @(negedge clk);
        rd(0, v); chk("R11 hw ignored pre-lock", v, 0);
        src = '0;
        // R10 master
        wr(7, 1); rd(7, v); chk("R10 master readback", v, 1);
        // sweep R8 / R9 / R11
        for (int p = 0; p < 256; p++) begin
            logic [N-1:0] e, pd;
            e  = N'(p) ^ 8'h5A;
            pd = N'(p) & e;
            wr(3, 32'hFFFF_FFFF);
            wr(0, 32'(p));
            wr(2, 32'(e));
            rd(0, v); chk("R11 sw status set", v, 32'(p));
            rd(1, v); chk("R8 pending", v, 32'(pd));
            rd(6, v); chk("R8 vector", v, lowest(pd));
            @(negedge clk);
            chk("R9 irq", 32'(irq), 32'(pd != 0));
        end
        // R9 gate off
        wr(0, 32'h01); wr(2, 32'h01); wr(7, 0); @(negedge clk);
        chk("R9 irq gated by master", 32'(irq), 0);
        // R5
        wr(0, 32'hFF); wr(3, 32'h0F); rd(0, v); chk("R5 partial ack", v, 32'hF0);
        wr(3, 32'hFFFF_FFFF); rd(0, v); chk("R5 ack all", v, 0);
        // R10 lock
        wr(7, 3); rd(7, v); chk("R10 both bits", v, 3);
        wr(7, 0); rd(7, v); chk("R10 hie sticky", v, 2);
        wr(7, 1); rd(7, v); chk("R10 me rewrite", v, 3);
        // R11 status write ignored after lock
        wr(0, 32'hFF); rd(0, v); chk("R11 sw write ignored", v, 0);
        // R6 level source bit 1
        @(negedge clk); src = 8'h02; @(negedge clk);
        rd(0, v); chk("R6 level sets", v, 32'h02);
        wr(3, 32'h02); rd(0, v); chk("R6 level re-sets on ack", v, 32'h02);
        src = '0; @(negedge clk);
        wr(3, 32'h02); rd(0, v); chk("R6 level clears when low", v, 0);
        // R7 edge source bit 5
        src = 8'h20; @(negedge clk);
        rd(0, v); chk("R7 edge sets", v, 32'h20);
        wr(3, 32'h20); @(negedge clk); rd(0, v); chk("R7 held edge stays clear", v, 0);
        src = '0; @(negedge clk); src = 8'h20; @(negedge clk);
        rd(0, v); chk("R7 re-edge sets", v, 32'h20);
        wr(2, 32'h20); @(negedge clk);
        chk("R9 irq from hw", 32'(irq), 1);
        rd(6, v); chk("R8 vector hw", v, 5);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule